// File: doc/BRIEF.md
# Serial Key Debug Unlock

This block guards a processor that runs its program from on-chip ROM. After reset the part is locked. In that state debug access and external boot sources are refused, and execution stays confined to internal ROM. A software owner may open the part by shifting a 64-bit secret through a serial test data register, one bit per shift strobe. The value is judged only when an update strobe arrives. A matching value opens the part for good, until the next reset. A mismatching value is dropped without trace.

The test access port controller is not part of the block. It is represented only by its shift and update strobes and the serial data bit. The reference key is a parameter. A build-time switch removes the protection altogether, and in that build the block reports open from reset.

Top module: `secu_unlock`

## Requirements
- R1: During and directly after reset (protection enabled) the block is locked: `unlocked_o`=0, `dbg_en_o`=0, `ext_boot_en_o`=0, `rom_only_o`=1.
- R2: Each cycle with `jtag_shift`=1 moves `jtag_tdi` into the key register LSB first. The first bit shifted of 64 ends up as key bit 0. Cycles with `jtag_shift`=0 leave the register unchanged.
- R3: The key is compared only on a cycle with `jtag_update`=1. If the register equals `USER_KEY`, the outputs open on the clock edge that samples the update. A fully shifted correct key without an update leaves the block locked.
- R4: An update with any other register value has no effect. All four outputs keep their values.
- R5: Once open, the block stays open until reset, including after later wrong keys. A reset locks it again.
- R6: Every update clears the key register to zero. Bits shifted before an update cannot combine with bits shifted after it.
- R7: When shift and update are both high in one cycle, the update wins and the serial bit is discarded.
- R8: Open means `unlocked_o`=1, `dbg_en_o`=1, `ext_boot_en_o`=1 and `rom_only_o`=0. Locked is the exact inverse of that pattern. All outputs come straight from flops.
- R9: With `SEC_EN`=0 the block is open from reset onward, whatever is shifted or updated.
- R10: Shifting more than 64 bits keeps only the last 64 bits shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jtag_shift | input | 1 | Shift strobe for the key data register |
| jtag_tdi | input | 1 | Serial key bit |
| jtag_update | input | 1 | Update strobe; triggers the key comparison |
| unlocked_o | output | 1 | Protection lifted |
| dbg_en_o | output | 1 | Debug/emulation access allowed |
| ext_boot_en_o | output | 1 | External boot sources allowed |
| rom_only_o | output | 1 | Execution confined to internal ROM |

## Verification
The comparison is tried with several key patterns, each paired with the behaviour it separates:
- an empty register, which would expose a compare that fires on reset contents;
- a key off by one bit, which would expose a partial compare;
- the correct key sent MSB first, which would expose a reversed shift direction;
- the two halves of the correct key split by an update, which would expose a register that is not cleared;
- a correct key whose last bit arrives together with the update, which would expose a wrong strobe priority;
- a correct key after junk bits and with idle gaps, which must open, so a register that does not hold or that drops old bits correctly is confirmed.

Wrong keys after opening, and a reset, show whether the open state is sticky. A second instance built without protection confirms that it is open throughout.

// File: rtl/secu_pkg.sv
package secu_pkg;

  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_OPEN   = 1'b1
  } lock_e;

  typedef struct packed {
    logic unlocked;
    logic dbg_en;
    logic ext_boot_en;
    logic rom_only;
  } grant_t;

  function automatic grant_t grant_of(lock_e st);
    grant_t g;
    g.unlocked    = (st == ST_OPEN);
    g.dbg_en      = (st == ST_OPEN);
    g.ext_boot_en = (st == ST_OPEN);
    g.rom_only    = (st == ST_LOCKED);
    return g;
  endfunction

endpackage

// File: rtl/secu_key_shifter.sv
module secu_key_shifter #(
  parameter int KEY_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             din,
  output logic [KEY_W-1:0] key_q
);

  // Update has priority and wipes the register; new bits enter at the MSB
  // so the first bit of a full key settles in bit 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
    end else if (update_en) begin
      key_q <= '0;
    end else if (shift_en) begin
      key_q <= {din, key_q[KEY_W-1:1]};
    end
  end

endmodule

// File: rtl/secu_key_match.sv
module secu_key_match #(
  parameter int               KEY_W    = 64,
  parameter int               LANE_W   = 16,
  parameter logic [KEY_W-1:0] USER_KEY = '0
) (
  input  logic [KEY_W-1:0] key_i,
  output logic             match_o
);

  localparam int N_LANES = (KEY_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W   = N_LANES * LANE_W;

  logic [PAD_W-1:0]   key_pad;
  logic [PAD_W-1:0]   ref_pad;
  logic [N_LANES-1:0] lane_eq;

  assign key_pad = PAD_W'(key_i);
  assign ref_pad = PAD_W'(USER_KEY);

  // Split the wide compare into lanes to keep each reduction shallow.
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    assign lane_eq[i] = (key_pad[i*LANE_W +: LANE_W] == ref_pad[i*LANE_W +: LANE_W]);
  end

  assign match_o = &lane_eq;

endmodule

// File: rtl/secu_lock_ctrl.sv
module secu_lock_ctrl
  import secu_pkg::*;
#(
  parameter bit SEC_EN = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   update_en,
  input  logic   match_i,
  output grant_t grant_o
);

  localparam lock_e RST_STATE = SEC_EN ? ST_LOCKED : ST_OPEN;

  lock_e state_q;
  lock_e state_nxt;

  if (SEC_EN) begin : g_secure
    always_comb begin
      state_nxt = state_q;
      if (update_en && match_i) begin
        state_nxt = ST_OPEN;
      end
    end
  end else begin : g_bypass
    always_comb begin
      state_nxt = ST_OPEN;
    end
  end

  // Grants are registered from the next state so they move with the state flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RST_STATE;
      grant_o <= grant_of(RST_STATE);
    end else begin
      state_q <= state_nxt;
      grant_o <= grant_of(state_nxt);
    end
  end

endmodule

// File: rtl/secu_unlock.sv
module secu_unlock
  import secu_pkg::*;
#(
  parameter int               KEY_W    = 64,
  parameter logic [KEY_W-1:0] USER_KEY = 64'hC3A5_1F70_9E42_D6B8,
  parameter bit               SEC_EN   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic jtag_shift,
  input  logic jtag_tdi,
  input  logic jtag_update,
  output logic unlocked_o,
  output logic dbg_en_o,
  output logic ext_boot_en_o,
  output logic rom_only_o
);

  logic [KEY_W-1:0] key_q;
  logic             key_match;
  grant_t           grant;

  secu_key_shifter #(.KEY_W(KEY_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (jtag_shift),
    .update_en (jtag_update),
    .din       (jtag_tdi),
    .key_q     (key_q)
  );

  secu_key_match #(.KEY_W(KEY_W), .LANE_W(16), .USER_KEY(USER_KEY)) u_match (
    .key_i   (key_q),
    .match_o (key_match)
  );

  secu_lock_ctrl #(.SEC_EN(SEC_EN)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .update_en (jtag_update),
    .match_i   (key_match),
    .grant_o   (grant)
  );

  assign unlocked_o    = grant.unlocked;
  assign dbg_en_o      = grant.dbg_en;
  assign ext_boot_en_o = grant.ext_boot_en;
  assign rom_only_o    = grant.rom_only;

endmodule

// File: rtl/secu_unlock_chk.sv
module secu_unlock_chk #(
  parameter int               KEY_W    = 64,
  parameter logic [KEY_W-1:0] USER_KEY = '0,
  parameter bit               SEC_EN   = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             jtag_shift,
  input logic             jtag_update,
  input logic [KEY_W-1:0] key_q,
  input logic             unlocked_o,
  input logic             dbg_en_o,
  input logic             ext_boot_en_o,
  input logic             rom_only_o
);

  // R5
  sticky_open_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked_o |=> unlocked_o);

  // R3
  open_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> $past(jtag_update));

  // R4
  wrong_key_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (jtag_update && !unlocked_o && (key_q != USER_KEY)) |=> !unlocked_o);

  // R6
  clear_on_update_chk: assert property (@(posedge clk) disable iff (rst)
    jtag_update |=> (key_q == '0));

  // R8
  locked_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !unlocked_o |-> (rom_only_o && !dbg_en_o && !ext_boot_en_o));

  // R9
  bypass_open_chk: assert property (@(posedge clk) disable iff (rst)
    !SEC_EN |-> unlocked_o);

  // R2
  hold_key_chk: assert property (@(posedge clk) disable iff (rst)
    (!jtag_shift && !jtag_update) |=> $stable(key_q));

endmodule

bind secu_unlock secu_unlock_chk #(.KEY_W(KEY_W), .USER_KEY(USER_KEY), .SEC_EN(SEC_EN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .jtag_shift    (jtag_shift),
  .jtag_update   (jtag_update),
  .key_q         (key_q),
  .unlocked_o    (unlocked_o),
  .dbg_en_o      (dbg_en_o),
  .ext_boot_en_o (ext_boot_en_o),
  .rom_only_o    (rom_only_o)
);

// File: tb/sim_secu_unlock.sv
module sim_secu_unlock;

  localparam logic [63:0] KEY = 64'hC3A5_1F70_9E42_D6B8;

  typedef struct {
    logic [3:0] outs;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sh = 1'b0, tdi = 1'b0, up = 1'b0;
  logic u0_unl, u0_dbg, u0_ext, u0_rom;
  logic u1_unl, u1_dbg, u1_ext, u1_rom;

  int   n_chk  = 0;
  int   n_fail = 0;
  logic exp_unl = 1'b0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  secu_unlock #(.USER_KEY(KEY), .SEC_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .jtag_shift(sh), .jtag_tdi(tdi), .jtag_update(up),
    .unlocked_o(u0_unl), .dbg_en_o(u0_dbg), .ext_boot_en_o(u0_ext), .rom_only_o(u0_rom));

  secu_unlock #(.USER_KEY(KEY), .SEC_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .jtag_shift(sh), .jtag_tdi(tdi), .jtag_update(up),
    .unlocked_o(u1_unl), .dbg_en_o(u1_dbg), .ext_boot_en_o(u1_ext), .rom_only_o(u1_rom));

  function automatic logic [3:0] pat(logic open);
    return open ? 4'b1110 : 4'b0001;
  endfunction

  // Driver: one cycle of stimulus, expectation for the outputs after the next edge.
  task automatic cyc(logic s, logic d, logic u, string tag);
    exp_t e;
    @(negedge clk);
    sh = s; tdi = d; up = u;
    e.outs = pat(exp_unl);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic do_reset(int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1'b1; sh = 1'b0; up = 1'b0;
      exp_unl = 1'b0;
      e.outs = pat(1'b0);
      e.tag  = "R1";
      sb.push_back(e);
    end
    @(negedge clk);
    rst = 1'b0;
    e.outs = pat(1'b0);
    e.tag  = "R1";
    sb.push_back(e);
  endtask

  task automatic shift_bits(logic [63:0] v, int lo, int hi, string tag);
    for (int i = lo; i <= hi; i++) cyc(1'b1, v[i], 1'b0, tag);
  endtask

  task automatic update(logic opens, string tag);
    if (opens) exp_unl = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, tag);
  endtask

  // Monitor: compare after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if ({u0_unl, u0_dbg, u0_ext, u0_rom} !== e.outs) begin
        n_fail++;
        $display("FAIL %s (R8 pattern): actual %b expected %b at %0t",
                 e.tag, {u0_unl, u0_dbg, u0_ext, u0_rom}, e.outs, $time);
      end
      n_chk++;
      // R9
      if ({u1_unl, u1_dbg, u1_ext, u1_rom} !== 4'b1110) begin
        n_fail++;
        $display("FAIL R9: actual %b expected %b at %0t",
                 {u1_unl, u1_dbg, u1_ext, u1_rom}, 4'b1110, $time);
      end
    end
  end

  task automatic run_all();
    logic [63:0] rev;
    for (int i = 0; i < 64; i++) rev[i] = KEY[63-i];
    do_reset(3);
    // R4: empty register
    update(1'b0, "R4");
    // R4: one bit wrong
    shift_bits(KEY ^ 64'h1, 0, 63, "R4");
    update(1'b0, "R4");
    // R2: MSB-first order must not open
    shift_bits(rev, 0, 63, "R2");
    update(1'b0, "R2");
    // R6: halves split by an update
    shift_bits(KEY, 0, 31, "R6");
    update(1'b0, "R6");
    shift_bits(KEY, 32, 63, "R6");
    update(1'b0, "R6");
    // R7: last bit together with update is lost
    shift_bits(KEY, 0, 62, "R7");
    cyc(1'b1, KEY[63], 1'b1, "R7");
    // R10 with junk first, R2 idle gaps, R3 no open before update
    shift_bits(64'hFF, 0, 7, "R10");
    shift_bits(KEY, 0, 31, "R10");
    for (int i = 0; i < 5; i++) cyc(1'b0, i[0], 1'b0, "R2");
    shift_bits(KEY, 32, 63, "R3");
    cyc(1'b0, 1'b0, 1'b0, "R3");
    update(1'b1, "R3");
    cyc(1'b0, 1'b0, 1'b0, "R8");
    // R5: wrong key after opening keeps it open
    shift_bits(~KEY, 0, 63, "R5");
    update(1'b0, "R5");
    update(1'b0, "R5");
    // R5: reset locks again
    do_reset(2);
    update(1'b0, "R5");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, "R1");
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        run_all();
        done = 1'b1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule